// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic timer. It sits on a simple word-addressed register bus and counts down from a programmable reload value. When the count reaches zero it reloads itself, so software gets a fixed-rate tick without reprogramming the block. Each pass from one to zero sets a sticky count flag, and the block can present that flag as a level interrupt request.

Counting runs either on every core clock cycle or on rising edges of a slower reference clock. The reference clock is asynchronous to the core clock and is synchronised inside the block. A read-only calibration word is fixed at build time. It tells software whether a reference clock is present, whether the 10 ms tick count is exact, and what that count is.

The bus has no wait states. Read data is combinational from the address while a read request is present. Writes and read side effects take effect on the next rising clock edge.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control word reads 0, except bit 2, which reads the value of `NOREF`. The reload and current words read 0 and `irq_o` is low.
- R2: The words are decoded on the full byte address. Control is at 0x0, reload at 0x4, current at 0x8 and calibration at 0xC. Any other address reads 0 and a write to it has no effect. Unused bits read 0. The reload word keeps only bits 23:0, so its largest value is 0xFFFFFF.
- R3: Control bit 0 enables counting. With bit 2 = 1 (core clock), the current value decreases by one on every clock cycle while it is nonzero.
- R4: A tick that finds the counter at 0 loads the reload value. A tick that takes the counter from 1 to 0 sets the count flag, which reads as control bit 16. With a reload of 0 the counter stays at 0 and the flag is never set.
- R5: A write of any data to the current word sets the counter to 0. This write takes priority over a tick in the same cycle, and the next tick loads the reload value without setting the flag.
- R6: With control bit 2 = 0 (reference clock), the counter steps once per rising edge of `ref_clk_i`. The edge passes through a two-flop synchroniser and an edge detector, so the counter steps on the third rising core-clock edge after the edge is first sampled.
- R7: While control bit 0 is 0, the current value holds.
- R8: A read of the control word clears the count flag. If a 1-to-0 step happens in the same cycle, the flag stays set. Writes to the control word leave the flag unchanged.
- R9: `irq_o` is high exactly when the count flag is set and control bit 1 is 1.
- R10: The calibration word is read-only. Bit 31 is `NOREF`, bit 30 is `SKEW`, bits 23:0 are `TENMS` and bits 29:24 are 0.
- R11: When `NOREF` is 1, control bit 2 always reads 1, a write of 0 to it has no effect, and the counter runs on the core clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address of the register word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while a read request is present |
| ref_clk_i | input | 1 | Asynchronous reference clock |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check, on every cycle, the stepping of the counter:
- it holds when there is no tick and no clear;
- it decrements or reloads on a tick;
- it is zeroed by a write to the current word.

They also check how the flag is set, held and cleared, and that the edge detector never emits two pulses in a row. Only the bench scenarios can show the parts that need a whole sequence:
- the period of reload + 1 ticks;
- the three-cycle latency from the reference clock;
- the silent reload after a clear or with a reload of zero;
- the fixed clock source when `NOREF` is set.

The bench shows these by comparing two instances against a cycle-accurate behavioural model.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int BUS_AW = 4;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFF_CTRL   = 4'h0;
    localparam logic [BUS_AW-1:0] OFF_RELOAD = 4'h4;
    localparam logic [BUS_AW-1:0] OFF_CUR    = 4'h8;
    localparam logic [BUS_AW-1:0] OFF_CALIB  = 4'hC;

    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    typedef struct packed {
        logic en;
        logic ie;
        logic src;
        logic flag;
    } ctrl_t;
endpackage

// File: rtl/st_ref_sync.sv
module st_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[CHAIN-2:0], ref_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // The last synchronised stage is high and the edge-history flop is still low.
    assign rise_o = s_q.chain[CHAIN-2] & ~s_q.chain[CHAIN-1];

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/st_down_counter.sv
module st_down_counter #(
    parameter int W = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         clr_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        wrap_o = 1'b0;
        if (clr_i) begin
            c_d.cnt = '0;
        end else if (tick_i) begin
            if (c_q.cnt == '0) begin
                c_d.cnt = reload_i;
            end else begin
                c_d.cnt = c_q.cnt - ONE;
                wrap_o  = (c_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign cnt_o = c_q.cnt;

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_i) |=> $stable(cnt_o));
    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0));
    a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !clr_i && cnt_o == '0) |=> (cnt_o == $past(reload_i)));
    a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !clr_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - ONE));
endmodule

// File: rtl/st_ctrl_regs.sv
module st_ctrl_regs
    import st_pkg::*;
#(
    parameter int          W     = 24,
    parameter bit          NOREF = 1'b0,
    parameter bit          SKEW  = 1'b0,
    parameter logic [23:0] TENMS = 24'd10000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [BUS_DW-1:0] wdata_i,
    output logic [BUS_DW-1:0] rdata_o,
    input  logic [W-1:0]      cnt_i,
    input  logic              wrap_i,
    output logic              en_o,
    output logic              src_o,
    output logic              clr_o,
    output logic [W-1:0]      reload_o,
    output logic              irq_o
);
    localparam logic [BUS_DW-1:0] CALIB_WORD = {NOREF, SKEW, 6'b0, TENMS};

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] reload;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr, rd, rd_ctrl;

    assign wr      = req_i & we_i;
    assign rd      = req_i & ~we_i;
    assign rd_ctrl = rd & (addr_i == OFF_CTRL);

    always_comb begin
        r_d = r_q;
        if (wr && addr_i == OFF_CTRL) begin
            r_d.ctrl.en  = wdata_i[BIT_EN];
            r_d.ctrl.ie  = wdata_i[BIT_IE];
            r_d.ctrl.src = NOREF ? 1'b1 : wdata_i[BIT_SRC];
        end
        if (wr && addr_i == OFF_RELOAD) r_d.reload = wdata_i[W-1:0];
        if (rd_ctrl) r_d.ctrl.flag = 1'b0;
        if (wrap_i)  r_d.ctrl.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q          <= '0;
            r_q.ctrl.src <= NOREF;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            case (addr_i)
                OFF_CTRL: begin
                    rdata_o[BIT_EN]   = r_q.ctrl.en;
                    rdata_o[BIT_IE]   = r_q.ctrl.ie;
                    rdata_o[BIT_SRC]  = r_q.ctrl.src;
                    rdata_o[BIT_FLAG] = r_q.ctrl.flag;
                end
                OFF_RELOAD: rdata_o = BUS_DW'(r_q.reload);
                OFF_CUR:    rdata_o = BUS_DW'(cnt_i);
                OFF_CALIB:  rdata_o = CALIB_WORD;
                default:    rdata_o = '0;
            endcase
        end
    end

    assign clr_o    = wr & (addr_i == OFF_CUR);
    assign en_o     = r_q.ctrl.en;
    assign src_o    = r_q.ctrl.src;
    assign reload_o = r_q.reload;
    assign irq_o    = r_q.ctrl.flag & r_q.ctrl.ie;

    a_r4_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> r_q.ctrl.flag);
    a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_ctrl && !wrap_i) |=> !r_q.ctrl.flag);
    a_r8_flag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_ctrl && !wrap_i) |=> $stable(r_q.ctrl.flag));
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import st_pkg::*;
#(
    parameter int          CNT_W       = 24,
    parameter int          SYNC_STAGES = 2,
    parameter bit          NOREF       = 1'b0,
    parameter bit          SKEW        = 1'b0,
    parameter logic [23:0] TENMS       = 24'd10000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_req_i,
    input  logic        bus_we_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    input  logic        ref_clk_i,
    output logic        irq_o
);
    logic             ref_rise, en, src, clr, wrap, tick;
    logic [CNT_W-1:0] cnt, reload;

    st_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_clk_i),
        .rise_o (ref_rise)
    );

    assign tick = en & (src | ref_rise);

    st_down_counter #(.W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .clr_i    (clr),
        .reload_i (reload),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    st_ctrl_regs #(.W(CNT_W), .NOREF(NOREF), .SKEW(SKEW), .TENMS(TENMS)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (bus_req_i),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .rdata_o  (bus_rdata_o),
        .cnt_i    (cnt),
        .wrap_i   (wrap),
        .en_o     (en),
        .src_o    (src),
        .clr_o    (clr),
        .reload_o (reload),
        .irq_o    (irq_o)
    );

    a_r11_src_pinned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        NOREF |-> src);
endmodule

// File: tb/tb_sys_tick_timer.sv
module tb_sys_tick_timer;
    localparam logic [23:0] TENMS = 24'h0ABCDE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, ref_drv = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata [2];
    logic        irq [2];
    int          n_cmp = 0, n_fail = 0;
    string       tag = "R1";
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sys_tick_timer #(.NOREF(1'b0), .SKEW(1'b1), .TENMS(TENMS)) dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata[0]),
        .ref_clk_i(ref_drv), .irq_o(irq[0]));

    sys_tick_timer #(.NOREF(1'b1), .SKEW(1'b1), .TENMS(TENMS)) dut_noref (
        .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata[1]),
        .ref_clk_i(ref_drv), .irq_o(irq[1]));

    // Behavioural reference model: index 0 has a reference clock, index 1 has none.
    bit          m_en [2], m_ie [2], m_src [2], m_flag [2];
    logic [23:0] m_rel [2], m_cur [2];
    bit          m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_en[k] = 0; m_ie[k] = 0; m_src[k] = (k == 1); m_flag[k] = 0;
                m_rel[k] = '0; m_cur[k] = '0;
            end
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit rise;
            rise = m_s2 && !m_s3;
            for (int k = 0; k < 2; k++) begin
                bit tk, wr;
                tk = m_en[k] && (m_src[k] || rise);
                wr = 0;
                if (req && we && addr == 4'h8) m_cur[k] = '0;
                else if (tk) begin
                    if (m_cur[k] == 0) m_cur[k] = m_rel[k];
                    else begin
                        wr = (m_cur[k] == 1);
                        m_cur[k] = m_cur[k] - 24'd1;
                    end
                end
                if (req && !we && addr == 4'h0) m_flag[k] = 0;
                if (wr) m_flag[k] = 1;
                if (req && we && addr == 4'h0) begin
                    m_en[k] = wdata[0]; m_ie[k] = wdata[1];
                    m_src[k] = (k == 1) ? 1'b1 : wdata[2];
                end
                if (req && we && addr == 4'h4) m_rel[k] = wdata[23:0];
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_drv;
        end
    end

    function automatic logic [31:0] model_read(int k, logic [3:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            4'h0: begin v[0] = m_en[k]; v[1] = m_ie[k]; v[2] = m_src[k]; v[16] = m_flag[k]; end
            4'h4: v = {8'h0, m_rel[k]};
            4'h8: v = {8'h0, m_cur[k]};
            4'hC: v = {(k == 1), 1'b1, 6'b0, TENMS};
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int k = 0; k < 2; k++) begin
                n_cmp++;
                if (irq[k] !== (m_flag[k] && m_ie[k])) begin
                    n_fail++;
                    $display("FAIL R9 inst%0d irq actual=%b expected=%b", k, irq[k], m_flag[k] && m_ie[k]);
                end
                if (req && !we) begin
                    n_cmp++;
                    if (rdata[k] !== model_read(k, addr)) begin
                        n_fail++;
                        $display("FAIL %s inst%0d addr=%h actual=%h expected=%h",
                                 tag, k, addr, rdata[k], model_read(k, addr));
                    end
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle(int n);
        req = 0;
        repeat (n) step();
    endtask

    task automatic wr_reg(logic [3:0] a, logic [31:0] d);
        req = 1; we = 1; addr = a; wdata = d;
        step();
        req = 0; we = 0;
    endtask

    task automatic rd_reg(logic [3:0] a);
        req = 1; we = 0; addr = a;
        step();
        req = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 and R10: reset state and calibration word
        tag = "R1";
        rd_reg(4'h0); rd_reg(4'h4); rd_reg(4'h8);
        tag = "R10";
        rd_reg(4'hC);
        wr_reg(4'hC, 32'hFFFF_FFFF);
        rd_reg(4'hC);
        // R2: reload width, misaligned addresses
        tag = "R2";
        wr_reg(4'h4, 32'h01FF_FFFF);
        rd_reg(4'h4);
        wr_reg(4'h5, 32'h0000_0033);
        rd_reg(4'h5); rd_reg(4'h4);
        // R3/R4: core clock, period reload+1, flag
        tag = "R3";
        wr_reg(4'h4, 32'd4);
        wr_reg(4'h8, 32'h55);
        wr_reg(4'h0, 32'h7);
        for (int i = 0; i < 14; i++) rd_reg(4'h8);
        tag = "R4";
        rd_reg(4'h0);
        // R8: the first read clears the flag, the second shows it cleared
        tag = "R8";
        rd_reg(4'h0); rd_reg(4'h0);
        wr_reg(4'h0, 32'h0001_0007);
        rd_reg(4'h0);
        // R9: interrupt disabled while the flag is set
        tag = "R9";
        wr_reg(4'h0, 32'h5);
        idle(8);
        rd_reg(4'h4);
        wr_reg(4'h0, 32'h7);
        idle(3);
        // R5: clear while running
        tag = "R5";
        wr_reg(4'h8, 32'hDEAD_BEEF);
        for (int i = 0; i < 4; i++) rd_reg(4'h8);
        // R7: disable holds the count
        tag = "R7";
        wr_reg(4'h0, 32'h4);
        rd_reg(4'h8); idle(5); rd_reg(4'h8);
        // R4: reload of zero stays at zero with no flag
        tag = "R4";
        rd_reg(4'h0);
        wr_reg(4'h4, 32'd0);
        wr_reg(4'h8, 32'd0);
        wr_reg(4'h0, 32'h7);
        idle(10);
        rd_reg(4'h8); rd_reg(4'h0);
        // R6 and R11: reference mode; the instance without a reference keeps the core clock
        tag = "R6";
        wr_reg(4'h4, 32'd6);
        wr_reg(4'h8, 32'd0);
        wr_reg(4'h0, 32'h3);
        tag = "R11";
        rd_reg(4'h0);
        tag = "R6";
        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 0) ref_drv = ~ref_drv;
            rd_reg(4'h8);
        end
        rd_reg(4'h0);
        idle(2);
        finish_run();
    end
endmodule